// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block sits between a set of I/O devices and the processor's control sequencer. Each device drives a request line and has its own enable bit, a 3-bit priority level and an 8-bit vector number. On every cycle the block works out which enabled, requesting device has the highest priority. That device may interrupt only if its level is strictly above the processor's current priority level.

The sequencer raises `insn_done` in the cycle in which the current instruction completes. If a device qualifies in that cycle, the block emits a one-cycle `take_irq` pulse on the next cycle. In the same cycle it presents two values: the address of the vector-table entry to fetch (0x0100 plus the device's vector number), and the priority level that the processor should adopt. Context saving, the mode switch and the return from the service routine all belong to the sequencer.

Top module: `irq_arbiter`

## Requirements
- R1: A device whose enable bit in `dev_en` is 0 never causes `take_irq`, whatever its request and priority.
- R2: A device whose request bit in `dev_req` is 0 never causes `take_irq`, whatever its enable and priority.
- R3: A device interrupts only if its priority is strictly greater than `cpu_prio`. A priority equal to or below `cpu_prio` produces no pulse.
- R4: `take_irq` is high only in the cycle right after a cycle in which `insn_done` was high and some device qualified. Each such boundary cycle yields exactly one one-cycle pulse. With `insn_done` low, no pulse is produced.
- R5: During a pulse, `vec_addr` equals 16'h0100 plus the zero-extended 8-bit vector of the winning device, so it lies in 0x0100..0x01FF. Device i's vector is `dev_vec[8*i+7:8*i]`.
- R6: Among qualifying devices, the one with the highest priority wins, and `grant_prio` shows its level during the pulse. Device i's priority is `dev_prio[3*i+2:3*i]`.
- R7: When several qualifying devices share the highest priority, the lowest device index wins.
- R8: When no pulse is issued, `vec_addr` and `grant_prio` keep the values of the last grant.
- R9: While `rst` is high and in the first cycle after it, `take_irq`, `vec_addr` and `grant_prio` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | N_DEV | Per-device request, bit i for device i |
| dev_en | input | N_DEV | Per-device interrupt enable |
| dev_prio | input | N_DEV*PRIO_W | Per-device priority, device i in slice [PRIO_W*i +: PRIO_W] |
| dev_vec | input | N_DEV*VEC_W | Per-device vector number, device i in slice [VEC_W*i +: VEC_W] |
| cpu_prio | input | PRIO_W | Priority level of the running program |
| insn_done | input | 1 | Instruction-boundary strobe |
| take_irq | output | 1 | One-cycle pulse: take the interrupt |
| vec_addr | output | ADDR_W | Vector-table entry address of the grant |
| grant_prio | output | PRIO_W | Priority level of the granted device |

## Verification
Corrupted selection logic shows up on the very next boundary. It appears as a wrong device's vector on `vec_addr`, a level on `grant_prio` that does not match the expected winner, or a pulse whose level is not above the `cpu_prio` sampled one cycle earlier. A damaged output register is exposed within one cycle in two ways: the pulse lasts longer than the boundary allows, or `vec_addr` and `grant_prio` drift during idle cycles when they should hold the last grant. Reset faults appear as nonzero outputs in the first cycle after reset, even while a qualifying request and strobe are present.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int IRQ_ADDR_W   = 16;
  localparam int IRQ_PRIO_W   = 3;
  localparam int IRQ_VEC_W    = 8;
  localparam int IRQ_N_DEV    = 4;
  localparam logic [IRQ_ADDR_W-1:0] IRQ_TBL_BASE = 16'h0100;

  function automatic logic [IRQ_ADDR_W-1:0] tbl_entry(
    input logic [IRQ_ADDR_W-1:0] base,
    input logic [IRQ_ADDR_W-1:0] vec_ext
  );
    return base + vec_ext;
  endfunction
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int N_DEV  = irq_arb_pkg::IRQ_N_DEV,
  parameter int PRIO_W = irq_arb_pkg::IRQ_PRIO_W
) (
  input  logic [N_DEV-1:0]        req,
  input  logic [N_DEV-1:0]        en,
  input  logic [N_DEV*PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]       floor_prio,
  output logic [N_DEV-1:0]        qual
);
  for (genvar g = 0; g < N_DEV; g++) begin : g_dev
    assign qual[g] = req[g] & en[g] & (prio[g*PRIO_W +: PRIO_W] > floor_prio);
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N_DEV  = irq_arb_pkg::IRQ_N_DEV,
  parameter int PRIO_W = irq_arb_pkg::IRQ_PRIO_W,
  parameter int VEC_W  = irq_arb_pkg::IRQ_VEC_W
) (
  input  logic [N_DEV-1:0]        qual,
  input  logic [N_DEV*PRIO_W-1:0] prio,
  input  logic [N_DEV*VEC_W-1:0]  vec,
  output logic                    found,
  output logic [PRIO_W-1:0]       win_prio,
  output logic [VEC_W-1:0]        win_vec
);
  // Ascending scan with strict compare: an equal level later in the scan
  // never displaces an earlier one, so the lower index keeps ties.
  always_comb begin
    found    = 1'b0;
    win_prio = '0;
    win_vec  = '0;
    for (int i = 0; i < N_DEV; i++) begin
      if (qual[i] && (!found || prio[i*PRIO_W +: PRIO_W] > win_prio)) begin
        found    = 1'b1;
        win_prio = prio[i*PRIO_W +: PRIO_W];
        win_vec  = vec[i*VEC_W +: VEC_W];
      end
    end
  end
endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg #(
  parameter int PRIO_W = irq_arb_pkg::IRQ_PRIO_W,
  parameter int VEC_W  = irq_arb_pkg::IRQ_VEC_W,
  parameter int ADDR_W = irq_arb_pkg::IRQ_ADDR_W,
  parameter logic [ADDR_W-1:0] TBL_BASE = irq_arb_pkg::IRQ_TBL_BASE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [PRIO_W-1:0] win_prio,
  input  logic [VEC_W-1:0]  win_vec,
  output logic              take,
  output logic [ADDR_W-1:0] addr,
  output logic [PRIO_W-1:0] level
);
  localparam int PAD_W = ADDR_W - VEC_W;

  logic [ADDR_W-1:0] next_addr;
  assign next_addr = TBL_BASE + {{PAD_W{1'b0}}, win_vec};

  always_ff @(posedge clk) begin
    if (rst) begin
      take  <= 1'b0;
      addr  <= '0;
      level <= '0;
    end else begin
      take <= fire;
      if (fire) begin
        addr  <= next_addr;
        level <= win_prio;
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_DEV  = irq_arb_pkg::IRQ_N_DEV,
  parameter int PRIO_W = irq_arb_pkg::IRQ_PRIO_W,
  parameter int VEC_W  = irq_arb_pkg::IRQ_VEC_W,
  parameter int ADDR_W = irq_arb_pkg::IRQ_ADDR_W,
  parameter logic [ADDR_W-1:0] TBL_BASE = irq_arb_pkg::IRQ_TBL_BASE
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_DEV-1:0]        dev_req,
  input  logic [N_DEV-1:0]        dev_en,
  input  logic [N_DEV*PRIO_W-1:0] dev_prio,
  input  logic [N_DEV*VEC_W-1:0]  dev_vec,
  input  logic [PRIO_W-1:0]       cpu_prio,
  input  logic                    insn_done,
  output logic                    take_irq,
  output logic [ADDR_W-1:0]       vec_addr,
  output logic [PRIO_W-1:0]       grant_prio
);
  logic [N_DEV-1:0]  qual;
  logic              found;
  logic [PRIO_W-1:0] win_prio;
  logic [VEC_W-1:0]  win_vec;
  logic              fire;

  irq_qualify #(.N_DEV(N_DEV), .PRIO_W(PRIO_W)) u_qual (
    .req(dev_req), .en(dev_en), .prio(dev_prio),
    .floor_prio(cpu_prio), .qual(qual)
  );

  irq_pick #(.N_DEV(N_DEV), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_pick (
    .qual(qual), .prio(dev_prio), .vec(dev_vec),
    .found(found), .win_prio(win_prio), .win_vec(win_vec)
  );

  assign fire = insn_done & found;

  irq_out_reg #(.PRIO_W(PRIO_W), .VEC_W(VEC_W), .ADDR_W(ADDR_W),
                .TBL_BASE(TBL_BASE)) u_out (
    .clk(clk), .rst(rst), .fire(fire), .win_prio(win_prio),
    .win_vec(win_vec), .take(take_irq), .addr(vec_addr), .level(grant_prio)
  );
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int N_DEV  = 4,
  parameter int PRIO_W = 3,
  parameter int VEC_W  = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] TBL_BASE = 16'h0100
) (
  input logic                    clk,
  input logic                    rst,
  input logic [N_DEV-1:0]        dev_req,
  input logic [N_DEV-1:0]        dev_en,
  input logic [PRIO_W-1:0]       cpu_prio,
  input logic                    insn_done,
  input logic                    take_irq,
  input logic [ADDR_W-1:0]       vec_addr,
  input logic [PRIO_W-1:0]       grant_prio
);
  localparam logic [ADDR_W-1:0] TBL_TOP = TBL_BASE + ADDR_W'((1 << VEC_W) - 1);

  AST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    ($past(dev_en) == '0) |-> !take_irq); // R1
  AST_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (rst)
    ($past(dev_req) == '0) |-> !take_irq); // R2
  AST_ABOVE_CPU: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> (grant_prio > $past(cpu_prio))); // R3
  AST_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> $past(insn_done)); // R4
  AST_ADDR_IN_TABLE: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> (vec_addr >= TBL_BASE && vec_addr <= TBL_TOP)); // R5
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !take_irq |-> ($stable(vec_addr) && $stable(grant_prio))); // R8
endmodule

bind irq_arbiter irq_arbiter_chk #(
  .N_DEV(N_DEV), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .ADDR_W(ADDR_W), .TBL_BASE(TBL_BASE)
) u_chk (
  .clk(clk), .rst(rst), .dev_req(dev_req), .dev_en(dev_en),
  .cpu_prio(cpu_prio), .insn_done(insn_done), .take_irq(take_irq),
  .vec_addr(vec_addr), .grant_prio(grant_prio)
);

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  dev_req = '0;
  logic [3:0]  dev_en = '0;
  logic [11:0] dev_prio = '0;
  logic [31:0] dev_vec = '0;
  logic [2:0]  cpu_prio = '0;
  logic        insn_done = 1'b0;
  logic        take_irq;
  logic [15:0] vec_addr;
  logic [2:0]  grant_prio;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  irq_arbiter dut_i (
    .clk(clk), .rst(rst), .dev_req(dev_req), .dev_en(dev_en),
    .dev_prio(dev_prio), .dev_vec(dev_vec), .cpu_prio(cpu_prio),
    .insn_done(insn_done), .take_irq(take_irq), .vec_addr(vec_addr),
    .grant_prio(grant_prio)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  en;
    logic [11:0] prio;   // {d3,d2,d1,d0}
    logic [31:0] vec;    // {d3,d2,d1,d0}
    logic [2:0]  cpu;
    logic        take;
    logic [7:0]  evec;   // expected vector (held value when no pulse)
    logic [2:0]  eprio;
  } row_t;

  localparam logic [31:0] VV = 32'h43322110;
  localparam int NROW = 9;
  localparam row_t TBL [0:NROW-1] = '{
    '{4'b0001, 4'b0001, {3'd0,3'd0,3'd0,3'd5}, VV, 3'd2, 1'b1, 8'h10, 3'd5}, // R5 lone device
    '{4'b1111, 4'b1111, {3'd4,3'd3,3'd6,3'd1}, VV, 3'd0, 1'b1, 8'h21, 3'd6}, // R6 highest wins
    '{4'b1111, 4'b1101, {3'd4,3'd3,3'd6,3'd1}, VV, 3'd0, 1'b1, 8'h43, 3'd4}, // R1 top disabled
    '{4'b1111, 4'b1111, {3'd1,3'd7,3'd7,3'd2}, VV, 3'd3, 1'b1, 8'h21, 3'd7}, // R7 tie
    '{4'b1111, 4'b1111, {3'd0,3'd5,3'd2,3'd6}, VV, 3'd6, 1'b0, 8'h21, 3'd7}, // R3 equal, R8 hold
    '{4'b0000, 4'b1111, {3'd7,3'd7,3'd7,3'd7}, VV, 3'd0, 1'b0, 8'h21, 3'd7}, // R2 no request
    '{4'b1010, 4'b0101, {3'd7,3'd7,3'd7,3'd7}, VV, 3'd0, 1'b0, 8'h21, 3'd7}, // R1 R2 disjoint
    '{4'b1000, 4'b1000, {3'd7,3'd0,3'd0,3'd0}, 32'hFF000000, 3'd6, 1'b1, 8'hFF, 3'd7}, // R5 top
    '{4'b0100, 4'b0100, {3'd0,3'd1,3'd0,3'd0}, 32'h43002110, 3'd0, 1'b1, 8'h00, 3'd1}  // R5 base
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input row_t r);
    dev_req = r.req; dev_en = r.en; dev_prio = r.prio;
    dev_vec = r.vec; cpu_prio = r.cpu;
  endtask

  initial begin : watchdog
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 take", {15'b0, take_irq}, 16'h0);
    check("R9 vec", vec_addr, 16'h0000);
    check("R9 prio", {13'b0, grant_prio}, 16'h0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NROW; i++) begin
      drive(TBL[i]);
      insn_done = 1'b1;
      @(negedge clk);
      check("R4 pulse", {15'b0, take_irq}, {15'b0, TBL[i].take});
      check("R5 vec", vec_addr, 16'h0100 + {8'h00, TBL[i].evec});
      check("R6 prio", {13'b0, grant_prio}, {13'b0, TBL[i].eprio});
      insn_done = 1'b0;
      @(negedge clk);
      check("R4 one cycle", {15'b0, take_irq}, 16'h0);
      check("R8 hold vec", vec_addr, 16'h0100 + {8'h00, TBL[i].evec});
    end

    // R4: qualifying request without a boundary gives no pulse
    drive(TBL[1]);
    insn_done = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R4 no strobe", {15'b0, take_irq}, 16'h0);
    end
    check("R8 idle hold", vec_addr, 16'h0100);

    // R4: back-to-back boundaries give one pulse each
    insn_done = 1'b1;
    @(negedge clk);
    check("R4 first", {15'b0, take_irq}, 16'h1);
    check("R6 first", {13'b0, grant_prio}, 16'h6);
    @(negedge clk);
    check("R4 second", {15'b0, take_irq}, 16'h1);
    insn_done = 1'b0;
    @(negedge clk);
    check("R4 end", {15'b0, take_irq}, 16'h0);

    // R9: reset wins over a qualifying boundary
    rst = 1'b1;
    insn_done = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 take in reset", {15'b0, take_irq}, 16'h0);
    check("R9 vec in reset", vec_addr, 16'h0000);
    check("R9 prio in reset", {13'b0, grant_prio}, 16'h0);
    insn_done = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R9 after reset", {15'b0, take_irq}, 16'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule